// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count and a direction flag. Each phase input is first brought into the local clock domain through a short synchronizer chain and can be inverted by its own polarity bit. The synchronized levels are compared with those seen one clock earlier to find transitions. The order of the two phases then decides whether a transition moves the position forward or backward.

A three-bit mode selects which transitions advance the count: those of phase A only, those of phase B only, or those of both (four counts per encoder cycle). The direction flag follows every single-phase transition, whatever the mode. The count runs between zero and a programmable reload limit and wraps at either end. The count only moves while the enable input is high.

Top module: `quad_enc_counter`

## Requirements
- R1: While reset is asserted, and right after it, `count` is 0 and `dir_down` is 0.
- R2: With `mode` = 3'b010 only transitions of processed phase A change the count, so one full forward encoder cycle adds 2.
- R3: With `mode` = 3'b001 only transitions of processed phase B change the count, so one full encoder cycle moves it by 2.
- R4: With `mode` = 3'b011 transitions of both phases change the count, so one full encoder cycle moves it by 4.
- R5: On a transition of phase A the step is upward when the new level of A differs from the level of B, and downward otherwise.
- R6: On a transition of phase B the step is upward when the new level of B equals the level of A, and downward otherwise.
- R7: `dir_down` (1 = downward, 0 = upward) is updated on every single-phase transition, even when the mode or the enable keeps the count from moving.
- R8: While `cnt_en` is 0 the count does not change.
- R9: A `mode` value other than 3'b001, 3'b010 or 3'b011 holds the count.
- R10: An upward step from a value at or above `reload` gives 0; a downward step from 0 gives `reload`; every other step moves by exactly one.
- R11: `pol_a` / `pol_b` set to 1 invert the matching raw phase before transition detection, which reverses the step direction of a normal sequence.
- R12: When both processed phases change in the same clock cycle, the count and `dir_down` stay unchanged.
- R13: A raw phase change sampled at rising edge k shows up on `count` after rising edge k + SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| pol_a | input | 1 | Inverts phase A when 1 |
| pol_b | input | 1 | Inverts phase B when 1 |
| mode | input | 3 | Counting mode: 001 B only, 010 A only, 011 both, others hold |
| reload | input | CNT_W | Upper wrap limit of the count |
| cnt_en | input | 1 | Count enable |
| count | output | CNT_W | Position count |
| dir_down | output | 1 | Direction of the last single-phase transition, 1 = down |

## Verification
The bench builds the counter with a 4-bit count and the default two-stage synchronizer. The narrow count lets short encoder sequences reach both wrap points, with the limit set to full scale (15) and to a small value (5). The two-stage chain makes the three-edge input-to-count latency directly observable. A behavioural model with queued input history is compared on every clock, alongside explicit checks on mode selection, polarity, enable, invalid modes and simultaneous phase changes.

// File: rtl/qei_pkg.sv
package qei_pkg;

   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_PHASE_B = 3'b001;
   localparam logic [MODE_W-1:0] MODE_PHASE_A = 3'b010;
   localparam logic [MODE_W-1:0] MODE_BOTH    = 3'b011;

   // Does the selected mode count the transition that was seen this cycle?
   function automatic logic mode_counts(input logic [MODE_W-1:0] m,
                                        input logic tr_a,
                                        input logic tr_b);
      case (m)
         MODE_PHASE_A: mode_counts = tr_a;
         MODE_PHASE_B: mode_counts = tr_b;
         MODE_BOTH:    mode_counts = 1'b1;
         default:      mode_counts = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/qei_sync.sv
module qei_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic invert,
   output logic level
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qei_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], raw};
   end

   assign level = chain[STAGES-1] ^ invert;

endmodule

// File: rtl/qei_decode.sv
module qei_decode
   import qei_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lvl_a,
   input  logic              lvl_b,
   input  logic              cnt_en,
   input  logic [MODE_W-1:0] mode,
   output logic              tr_a,
   output logic              tr_b,
   output logic              step,
   output logic              step_up,
   output logic              dir_down
);

   logic prev_a, prev_b;
   logic single;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_a <= 1'b0;
         prev_b <= 1'b0;
      end else begin
         prev_a <= lvl_a;
         prev_b <= lvl_b;
      end
   end

   assign tr_a   = lvl_a ^ prev_a;
   assign tr_b   = lvl_b ^ prev_b;
   assign single = tr_a ^ tr_b;

   // Phase A moving away from B's level, or B moving onto A's level, is forward.
   assign step_up = tr_a ? (lvl_a != lvl_b) : (lvl_b == lvl_a);
   assign step    = single & cnt_en & mode_counts(mode, tr_a, tr_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_down <= 1'b0;
      else if (single) dir_down <= ~step_up;
   end

endmodule

// File: rtl/qei_wrap_cnt.sv
module qei_wrap_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         step_up,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt
);

   generate
      if (W < 2) begin : g_bad_width
         $error("qei_wrap_cnt: W must be at least 2");
      end
   endgenerate

   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] nxt_up, nxt_dn;

   assign nxt_up = (cnt >= limit) ? '0 : cnt + ONE;
   assign nxt_dn = (cnt == '0) ? limit : cnt - ONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= step_up ? nxt_up : nxt_dn;
   end

endmodule

// File: rtl/quad_enc_counter.sv
module quad_enc_counter
   import qei_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_a,
   input  logic              enc_b,
   input  logic              pol_a,
   input  logic              pol_b,
   input  logic [MODE_W-1:0] mode,
   input  logic [CNT_W-1:0]  reload,
   input  logic              cnt_en,
   output logic [CNT_W-1:0]  count,
   output logic              dir_down
);

   localparam int N_PH = 2;

   logic [N_PH-1:0] raw_v, inv_v, lvl_v;
   logic            edge_a, edge_b;
   logic            step, step_up;

   assign raw_v = {enc_b, enc_a};
   assign inv_v = {pol_b, pol_a};

   generate
      for (genvar ph = 0; ph < N_PH; ph++) begin : g_phase
         qei_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw    (raw_v[ph]),
            .invert (inv_v[ph]),
            .level  (lvl_v[ph])
         );
      end
   endgenerate

   qei_decode u_decode (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_a    (lvl_v[0]),
      .lvl_b    (lvl_v[1]),
      .cnt_en   (cnt_en),
      .mode     (mode),
      .tr_a     (edge_a),
      .tr_b     (edge_b),
      .step     (step),
      .step_up  (step_up),
      .dir_down (dir_down)
   );

   qei_wrap_cnt #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .step_up (step_up),
      .limit   (reload),
      .cnt     (count)
   );

endmodule

// File: rtl/quad_enc_counter_chk.sv
module quad_enc_counter_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       mode,
   input logic             cnt_en,
   input logic [CNT_W-1:0] reload,
   input logic [CNT_W-1:0] count,
   input logic             dir_down,
   input logic             edge_a,
   input logic             edge_b
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // R10: each change of the count is one step or a wrap
   assert_legal_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (count != $past(count)) |->
         (count == $past(count) + ONE) || (count == $past(count) - ONE) ||
         (count == '0 && $past(count) >= $past(reload)) ||
         (count == $past(reload) && $past(count) == '0));

   // R8: disabled counter holds
   assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> $stable(count));

   // R9: undefined modes hold
   assert_hold_bad_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 3'b001 && mode != 3'b010 && mode != 3'b011) |=> $stable(count));

   // R12: simultaneous transitions change nothing
   assert_both_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_a && edge_b) |=> ($stable(count) && $stable(dir_down)));

   // R7: direction moves only on a transition
   assert_dir_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(edge_a || edge_b) |=> $stable(dir_down));

endmodule

bind quad_enc_counter quad_enc_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode     (mode),
   .cnt_en   (cnt_en),
   .reload   (reload),
   .count    (count),
   .dir_down (dir_down),
   .edge_a   (edge_a),
   .edge_b   (edge_b)
);

// File: tb/quad_enc_counter_bench.sv
module quad_enc_counter_bench;

   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enc_a = 1'b0, enc_b = 1'b0;
   logic          pol_a = 1'b0, pol_b = 1'b0;
   logic [2:0]    mode = 3'b011;
   logic [CW-1:0] reload = 4'd15;
   logic          cnt_en = 1'b0;
   logic [CW-1:0] count;
   logic          dir_down;

   int    checks = 0;
   int    failures = 0;
   int    ph = 0;
   string tag = "R1";

   always #4 clk = ~clk;

   quad_enc_counter #(.CNT_W(CW)) u_quad_enc_counter (
      .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
      .pol_a(pol_a), .pol_b(pol_b), .mode(mode), .reload(reload),
      .cnt_en(cnt_en), .count(count), .dir_down(dir_down)
   );

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
      end
   endtask

   task automatic chk_state(input int ecnt, input int edir, input string t);
      chk(int'(count) == ecnt, {t, " count"}, int'(count), ecnt);
      chk(int'(dir_down) == edir, {t, " dir"}, int'(dir_down), edir);
   endtask

   // ---------------- behavioural reference model ----------------
   bit q_a[$], q_b[$];
   bit m_prev_a, m_prev_b;
   int m_cnt;
   bit m_dir;

   always @(posedge clk) begin
      bit pa, pb, ea, eb, up, sel;
      int lim;
      if (!rst_n) begin
         q_a = {}; q_b = {};
         m_prev_a = 0; m_prev_b = 0; m_cnt = 0; m_dir = 0;
      end else begin
         lim = int'(reload);
         pa = ((q_a.size() > 1) ? q_a[1] : 1'b0) ^ pol_a;
         pb = ((q_b.size() > 1) ? q_b[1] : 1'b0) ^ pol_b;
         ea = (pa != m_prev_a);
         eb = (pb != m_prev_b);
         if (ea != eb) begin
            up    = ea ? (pa != pb) : (pb == pa);
            m_dir = !up;
            sel   = (mode == 3'b011) || (mode == 3'b010 && ea) || (mode == 3'b001 && eb);
            if (cnt_en && sel) begin
               if (up) m_cnt = (m_cnt >= lim) ? 0 : m_cnt + 1;
               else    m_cnt = (m_cnt == 0) ? lim : m_cnt - 1;
            end
         end
         m_prev_a = pa;
         m_prev_b = pb;
         q_a.push_front(enc_a);
         q_b.push_front(enc_b);
         if (q_a.size() > 2) void'(q_a.pop_back());
         if (q_b.size() > 2) void'(q_b.pop_back());
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk(int'(count) == m_cnt, {"model ", tag}, int'(count), m_cnt);
         chk(dir_down == m_dir, {"model dir ", tag}, int'(dir_down), int'(m_dir));
      end
   end

   // ---------------- stimulus helpers ----------------
   function automatic logic [1:0] ph_levels(input int p);
      case (p & 3)
         0: return 2'b00;   // {b,a}
         1: return 2'b01;
         2: return 2'b11;
         default: return 2'b10;
      endcase
   endfunction

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic go(input int n, input bit fwd);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ph = fwd ? ph + 1 : ph + 3;
         {enc_b, enc_a} = ph_levels(ph);
         repeat (3) @(negedge clk);
      end
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_state(0, 0, "R1 during reset");
      rst_n = 1'b1;
      settle();
      chk_state(0, 0, "R1 after reset");

      // R13 latency: change at a negedge, sampled at edge k, visible after k+2
      tag = "R13";
      cnt_en = 1'b1;
      @(negedge clk);
      ph = 1;
      {enc_b, enc_a} = ph_levels(ph);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk(int'(count) == 0, "R13 before latency", int'(count), 0);
      @(posedge clk); @(negedge clk);
      chk(int'(count) == 1, "R13 after latency", int'(count), 1);
      settle();

      tag = "R4";
      go(5, 1'b1);
      chk_state(6, 0, "R4 R5 R6 both phases forward");

      tag = "R10";
      go(8, 1'b0);
      chk_state(14, 1, "R10 down wrap to reload 15");
      go(2, 1'b1);
      chk_state(0, 0, "R10 up wrap at 15");

      tag = "R2";
      mode = 3'b010;
      go(8, 1'b1);
      chk_state(4, 0, "R2 phase A only");

      tag = "R3";
      mode = 3'b001;
      go(8, 1'b0);
      chk_state(0, 1, "R3 phase B only reverse");

      tag = "R7";
      go(1, 1'b1);
      chk_state(0, 0, "R7 A edge uncounted in mode 001 sets dir up");
      go(1, 1'b0);
      chk_state(0, 1, "R7 A edge uncounted sets dir down");

      tag = "R8";
      mode = 3'b011;
      cnt_en = 1'b0;
      go(5, 1'b1);
      chk_state(0, 0, "R8 disabled holds, R7 dir follows");

      tag = "R9";
      cnt_en = 1'b1;
      mode = 3'b111;
      go(3, 1'b0);
      chk_state(0, 1, "R9 mode 111 holds");
      mode = 3'b000;
      go(2, 1'b1);
      chk_state(0, 0, "R9 mode 000 holds");

      tag = "R10";
      mode = 3'b011;
      reload = 4'd5;
      go(7, 1'b1);
      chk_state(1, 0, "R10 up wrap at reload 5");
      go(3, 1'b0);
      chk_state(4, 1, "R10 down wrap to reload 5");

      tag = "R11";
      @(negedge clk);
      pol_a = 1'b1;
      settle();
      chk_state(5, 0, "R11 polarity flip seen as A edge");
      go(4, 1'b1);
      chk_state(1, 1, "R11 inverted A reverses forward sequence");

      tag = "R12";
      @(negedge clk);
      pol_a = 1'b0;
      settle();
      chk_state(0, 1, "R12 setup");
      @(negedge clk);
      {enc_b, enc_a} = 2'b11;
      settle();
      chk_state(0, 1, "R12 both rise together ignored");
      @(negedge clk);
      {enc_b, enc_a} = 2'b00;
      settle();
      chk_state(0, 1, "R12 both fall together ignored");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule